// File: doc/BRIEF.md
# Multi-Channel Timer Output Compare Unit

A timer peripheral built around a 16-bit free-running counter and five output-compare channels. Each channel has a 16-bit compare register. In every cycle in which the counter is enabled, each channel compares its register with the current count. On a hit, the channel sets its bit in a flag register. If that channel's interrupt-enable bit is also set, the combined interrupt output goes high.

Channels 2 to 5 each own one output pin. A two-bit control field per channel chooses what that pin does on a hit: hold, toggle, drive low or drive high. Channel 1 is the master channel. On its hit, every pin selected by a mask register takes the level held in the same bit of a data register.

Together the two kinds of action give single pulses. A slave channel sets the leading edge and the master channel restores the idle level. Software reaches all state through a small register interface with a single-cycle write and a combinational read.

Top module: `oc_timer_unit`

## Requirements
- R1: The counter (address 0, read-only) increments by one at each clock edge where `cntEn` is 1, holds while `cntEn` is 0, and wraps from 16'hFFFF to 16'h0000.
- R2: After reset every compare register reads 16'hFFFF, and the counter, flags, pins, control, mask, data and interrupt-enable registers read 0.
- R3: Compare register of channel i (i = 1..5) sits at address i. When `cntEn` is 1 and the count equals that register, flag bit i-1 (flag register, address 12) is set at the edge that ends that cycle, and not earlier.
- R4: Writing the flag register clears each bit written as 1. Bits written as 0 are left unchanged.
- R5: `irq` is high exactly when some flag bit is set whose bit in the interrupt-enable register (address 13) is also 1.
- R6: The control register (address 9) holds one two-bit field per channel c = 2..5 at bits [2(c-2)+1 : 2(c-2)]. On a hit of channel c, pin c-1 acts as follows: 00 holds, 01 toggles, 10 goes low, 11 goes high.
- R7: The pin action happens on every hit, whether or not the channel's flag was cleared after an earlier hit.
- R8: On a channel 1 hit, every pin k whose bit k is set in the mask register (address 10) takes bit k of the data register (address 11). Unmasked pins are left to their own channels.
- R9: When channel 1 and another channel hit in the same cycle, channel 1's data sets the pins it masks.
- R10: A single pulse results from a slave channel driving a pin high at one count and a masked channel 1 hit with data 0 returning it low at a later count.
- R11: Pins never change across an edge at which `cntEn` was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntEn | input | 1 | Counter advance and compare enable for this cycle |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data at `addr` |
| pinOut | output | 5 | Compare output pins, bit k driven by channel k+1 or the master |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong count or compare value shows up first as a flag that rises at the wrong edge. The bench measures that edge exactly, one cycle before and one cycle after the expected hit. A wrong pin action or a wrong master priority shows up on `pinOut` at the edge that ends the hit cycle. Each such case is sampled in the half cycle that follows that edge. Flag state that was not cleared is then carried into a second hit, which would expose a toggle that was wrongly gated by the flag.

// File: rtl/oc_timer_pkg.sv
package oc_timer_pkg;
  localparam int OC_AW      = 4;
  localparam int OC_MAX_CH  = 8;
  localparam logic [OC_AW-1:0] ADDR_CNT   = 4'd0;
  localparam logic [OC_AW-1:0] ADDR_CTL   = 4'(OC_MAX_CH + 1);
  localparam logic [OC_AW-1:0] ADDR_MASK  = 4'(OC_MAX_CH + 2);
  localparam logic [OC_AW-1:0] ADDR_DATA  = 4'(OC_MAX_CH + 3);
  localparam logic [OC_AW-1:0] ADDR_FLAG  = 4'(OC_MAX_CH + 4);
  localparam logic [OC_AW-1:0] ADDR_IEN   = 4'(OC_MAX_CH + 5);

  typedef enum logic [1:0] {
    PIN_HOLD   = 2'b00,
    PIN_TOGGLE = 2'b01,
    PIN_LOW    = 2'b10,
    PIN_HIGH   = 2'b11
  } pinAct_e;

  typedef struct packed {
    logic             wrCmp;
    logic [OC_AW-1:0] cmpSel;
    logic             wrCtl;
    logic             wrMask;
    logic             wrData;
    logic             clrFlags;
    logic             wrIen;
  } ocStrobe_t;
endpackage

// File: rtl/oc_timer_ctrl.sv
module oc_timer_ctrl
  import oc_timer_pkg::*;
#(
  parameter int NCH = 5
) (
  input  logic             wrEn,
  input  logic [OC_AW-1:0] addr,
  output ocStrobe_t        stb
);
  always_comb begin
    stb          = '0;
    stb.cmpSel   = addr;
    stb.wrCmp    = wrEn && (addr >= 4'd1) && (addr <= 4'(NCH));
    stb.wrCtl    = wrEn && (addr == ADDR_CTL);
    stb.wrMask   = wrEn && (addr == ADDR_MASK);
    stb.wrData   = wrEn && (addr == ADDR_DATA);
    stb.clrFlags = wrEn && (addr == ADDR_FLAG);
    stb.wrIen    = wrEn && (addr == ADDR_IEN);
  end
endmodule

// File: rtl/oc_timer_datapath.sv
module oc_timer_datapath
  import oc_timer_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  ocStrobe_t        stb,
  input  logic [CW-1:0]    wrData,
  input  logic [OC_AW-1:0] rdAddr,
  output logic [CW-1:0]    rdData,
  output logic [NCH-1:0]   pinOut,
  output logic             irq,
  output logic [CW-1:0]    cntVal,
  output logic [CW-1:0]    cmpMaster,
  output logic [NCH-1:0]   maskVal,
  output logic [NCH-1:0]   dataVal,
  output logic             flagMaster
);
  localparam int CTLW = 2 * (NCH - 1);

  logic [CW-1:0]   count;
  logic [CW-1:0]   cmpReg [NCH];
  logic [CTLW-1:0] ctlReg;
  logic [NCH-1:0]  ocMask, ocData, flags, ienReg, pins;
  logic [NCH-1:0]  hit;
  logic [NCH-1:0]  pinNext, clrMask;

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    assign hit[i] = cntEn && (count == cmpReg[i]);
    always_ff @(posedge clk) begin
      if (!rstN)
        cmpReg[i] <= '1;
      else if (stb.wrCmp && stb.cmpSel == OC_AW'(i + 1))
        cmpReg[i] <= wrData;
    end
  end

  always_comb begin
    pinNext = pins;
    for (int c = 1; c < NCH; c++) begin
      if (hit[c]) begin
        case (pinAct_e'(ctlReg[2*(c-1) +: 2]))
          PIN_TOGGLE: pinNext[c] = ~pins[c];
          PIN_LOW:    pinNext[c] = 1'b0;
          PIN_HIGH:   pinNext[c] = 1'b1;
          default:    pinNext[c] = pins[c];
        endcase
      end
    end
    if (hit[0])
      pinNext = (pinNext & ~ocMask) | (ocData & ocMask);
  end

  assign clrMask = stb.clrFlags ? wrData[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      ctlReg <= '0;
      ocMask <= '0;
      ocData <= '0;
      flags  <= '0;
      ienReg <= '0;
      pins   <= '0;
    end else begin
      if (cntEn) count <= count + 1'b1;
      if (stb.wrCtl)  ctlReg <= wrData[CTLW-1:0];
      if (stb.wrMask) ocMask <= wrData[NCH-1:0];
      if (stb.wrData) ocData <= wrData[NCH-1:0];
      if (stb.wrIen)  ienReg <= wrData[NCH-1:0];
      flags <= (flags & ~clrMask) | hit;
      pins  <= pinNext;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_CNT) rdData = count;
    for (int i = 0; i < NCH; i++)
      if (rdAddr == OC_AW'(i + 1)) rdData = cmpReg[i];
    if (rdAddr == ADDR_CTL)  rdData[CTLW-1:0] = ctlReg;
    if (rdAddr == ADDR_MASK) rdData[NCH-1:0]  = ocMask;
    if (rdAddr == ADDR_DATA) rdData[NCH-1:0]  = ocData;
    if (rdAddr == ADDR_FLAG) rdData[NCH-1:0]  = flags;
    if (rdAddr == ADDR_IEN)  rdData[NCH-1:0]  = ienReg;
  end

  assign pinOut     = pins;
  assign irq        = |(flags & ienReg);
  assign cntVal     = count;
  assign cmpMaster  = cmpReg[0];
  assign maskVal    = ocMask;
  assign dataVal    = ocData;
  assign flagMaster = flags[0];
endmodule

// File: rtl/oc_timer_unit.sv
module oc_timer_unit
  import oc_timer_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  logic             wrEn,
  input  logic [OC_AW-1:0] addr,
  input  logic [CW-1:0]    wrData,
  output logic [CW-1:0]    rdData,
  output logic [NCH-1:0]   pinOut,
  output logic             irq
);
  ocStrobe_t      stb;
  logic [CW-1:0]  cntVal, cmpMaster;
  logic [NCH-1:0] maskVal, dataVal;
  logic           flagMaster;

  oc_timer_ctrl #(.NCH(NCH)) ctrlI (
    .wrEn(wrEn), .addr(addr), .stb(stb)
  );

  oc_timer_datapath #(.CW(CW), .NCH(NCH)) dpI (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .stb(stb), .wrData(wrData),
    .rdAddr(addr), .rdData(rdData), .pinOut(pinOut), .irq(irq),
    .cntVal(cntVal), .cmpMaster(cmpMaster), .maskVal(maskVal),
    .dataVal(dataVal), .flagMaster(flagMaster)
  );
endmodule

// File: rtl/oc_timer_chk.sv
module oc_timer_chk #(
  parameter int CW  = 16,
  parameter int NCH = 5
) (
  input logic           clk,
  input logic           rstN,
  input logic           cntEn,
  input logic [NCH-1:0] pinOut,
  input logic [CW-1:0]  cntVal,
  input logic [CW-1:0]  cmpMaster,
  input logic [NCH-1:0] maskVal,
  input logic [NCH-1:0] dataVal,
  input logic           flagMaster
);
  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntEn |=> cntVal == CW'($past(cntVal) + 1'b1));

  // R1
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |=> $stable(cntVal));

  // R3
  master_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && cntVal == cmpMaster) |=> flagMaster);

  // R11
  pins_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |=> $stable(pinOut));

  for (genvar k = 0; k < NCH; k++) begin : g_ovr
    // R9
    master_override_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cntEn && cntVal == cmpMaster && maskVal[k]) |=> pinOut[k] == $past(dataVal[k]));
  end
endmodule

bind oc_timer_unit oc_timer_chk #(.CW(CW), .NCH(NCH)) chkI (
  .clk(clk), .rstN(rstN), .cntEn(cntEn), .pinOut(pinOut), .cntVal(cntVal),
  .cmpMaster(cmpMaster), .maskVal(maskVal), .dataVal(dataVal),
  .flagMaster(flagMaster)
);

// File: tb/tb_oc_timer_unit.sv
`timescale 1ns/1ps
module tb_oc_timer_unit;
  localparam int CW = 16;
  localparam int NCH = 5;

  logic clk = 0, rstN = 0, cntEn = 0, wrEn = 0;
  logic [3:0] addr = '0;
  logic [CW-1:0] wrData = '0, rdData;
  logic [NCH-1:0] pinOut;
  logic irq;
  int checks = 0, fails = 0;
  bit finished = 0;

  oc_timer_unit #(.CW(CW), .NCH(NCH)) dut (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pinOut(pinOut), .irq(irq)
  );

  always #2.5 clk = ~clk;

  // rows: {channel[2:0], mode[1:0], pin after first hit, pin after second hit}
  localparam logic [6:0] ROWS [7] = '{
    {3'd2, 2'b00, 1'b0, 1'b0},
    {3'd2, 2'b01, 1'b1, 1'b0},
    {3'd2, 2'b10, 1'b0, 1'b0},
    {3'd2, 2'b11, 1'b1, 1'b1},
    {3'd5, 2'b01, 1'b1, 1'b0},
    {3'd3, 2'b11, 1'b1, 1'b1},
    {3'd4, 2'b01, 1'b1, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0; cntEn = 0; wrEn = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  task automatic wr(logic [3:0] a, logic [CW-1:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [CW-1:0] d);
    @(negedge clk); addr = a; #1 d = rdData;
  endtask

  task automatic run(int n);
    @(negedge clk); cntEn = 1;
    repeat (n) @(posedge clk);
    @(negedge clk); cntEn = 0;
  endtask

  initial begin
    #750us;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] v;
    // R2 reset state
    doReset();
    for (int i = 1; i <= NCH; i++) begin rd(4'(i), v); check("R2 cmp reset", v, 16'hFFFF); end
    rd(4'd0, v); check("R2 count reset", v, 0);
    rd(4'd12, v); check("R2 flags reset", v, 0);
    check("R2 pins reset", pinOut, 0);
    check("R2 irq reset", irq, 0);

    // R6 R7 table walk: second hit with flag left set
    foreach (ROWS[r]) begin
      automatic int ch = ROWS[r][6:4];
      doReset();
      wr(4'd9, CW'(ROWS[r][3:2]) << (2 * (ch - 2)));
      wr(4'(ch), 16'd10);
      run(11);
      check("R6 first hit pin", pinOut[ch-1], ROWS[r][1]);
      rd(4'd12, v); check("R3 flag after hit", v[ch-1], 1);
      wr(4'(ch), 16'd15);
      run(5);
      check("R7 second hit pin", pinOut[ch-1], ROWS[r][0]);
    end

    // R3 R4 R5 flag timing, clear and interrupt
    doReset();
    wr(4'd3, 16'd4);
    run(4);
    rd(4'd12, v); check("R3 no flag before hit", v, 0);
    run(1);
    rd(4'd12, v); check("R3 flag at hit edge", v, 16'h0004);
    check("R5 irq masked off", irq, 0);
    wr(4'd13, 16'h0004);
    check("R5 irq enabled", irq, 1);
    wr(4'd12, 16'h0000);
    rd(4'd12, v); check("R4 write zero keeps", v, 16'h0004);
    wr(4'd12, 16'h0004);
    rd(4'd12, v); check("R4 write one clears", v, 0);
    check("R5 irq after clear", irq, 0);
    rd(4'd0, v); check("R1 count holds", v, 16'd5);

    // R8 R9 master override with coincident toggle
    doReset();
    wr(4'd9, 16'h0001);
    wr(4'd2, 16'd20);
    wr(4'd1, 16'd20);
    wr(4'd10, 16'h0007);
    wr(4'd11, 16'h0005);
    run(21);
    check("R9 R8 master wins", pinOut, 5'b00101);

    // R10 single pulse on pin 4
    doReset();
    wr(4'd9, 16'h00C0);
    wr(4'd5, 16'd30);
    wr(4'd1, 16'd40);
    wr(4'd10, 16'h0010);
    wr(4'd11, 16'h0000);
    run(31);
    check("R10 leading edge", pinOut[4], 1);
    repeat (3) @(negedge clk);
    check("R11 pin idle", pinOut[4], 1);
    run(9);
    check("R10 pulse held", pinOut[4], 1);
    run(1);
    check("R10 trailing edge", pinOut[4], 0);

    // R1 R2 wrap and default compare hits
    doReset();
    run(65535);
    rd(4'd0, v); check("R1 count at top", v, 16'hFFFF);
    rd(4'd12, v); check("R2 no early hit", v, 0);
    run(1);
    rd(4'd0, v); check("R1 wrap to zero", v, 0);
    rd(4'd12, v); check("R2 default compare hits", v, 16'h001F);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule